// File: doc/BRIEF.md
# Windowed Stream Join Compare Array

This block joins one batch of tuples from one stream against a sequence of tuples from the opposite stream. Every tuple has a value and a timestamp. A batch of N tuples is written into N compare elements first. Then the opposite-stream tuples travel down a pipeline, moving one element per clock. Each element compares the passing tuple against the tuple it holds.

A pair is joined when the two values are equal and the two timestamps are at most WIN apart. Each joined pair is held in a one-entry register inside its element. A round-robin arbiter empties those registers into a single registered valid/ready result port. A joined result carries the value, both timestamps, the later of the two timestamps and the index of the element that matched.

An element may find a new match while its register is still occupied. In that case the whole pipeline stops, so no result is dropped. When the final streamed tuple has left the pipeline and every result has been taken, the block gives a one-cycle completion pulse. It is then ready to load the next batch.

Top module: `sjoin_array`

## Requirements
- R1: After reset, res_valid and batch_done are 0, load_ready is 1 and old_ready is 0.
- R2: load_ready stays 1 until N load handshakes have been taken. Handshake k writes element k, counting from 0. On the cycle after the N-th handshake, load_ready is 0 and old_ready is 1.
- R3: Element i joins a streamed tuple when two conditions hold: the tuple's value equals the value of the batch tuple loaded into element i, and the absolute difference of the two timestamps is at most WIN. The interval is closed, so a difference of exactly WIN joins.
- R4: Each result gives the following fields:
  - res_val: the shared value.
  - res_new_ts: the batch tuple's timestamp.
  - res_old_ts: the streamed tuple's timestamp.
  - res_ts: the larger of the two timestamps.
  - res_slot: the element index i.
- R5: For every joined (element, streamed tuple) pair, exactly one result is produced. This holds when several elements match in the same cycle and when the result port is held back.
- R6: While res_valid is 1 and res_ready is 0, res_valid and all result fields keep their values into the next cycle.
- R7: batch_done pulses for one cycle only after two things have happened: the streamed tuple marked old_last has been taken, and every result of the batch has been accepted. In that cycle load_ready is 1 and res_valid is 0, and no further result appears before the next batch is loaded.
- R8: A pair whose values differ, or whose timestamps differ by more than WIN (including WIN+1), produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Batch tuple offered |
| load_val | input | VAL_W | Batch tuple value |
| load_ts | input | TS_W | Batch tuple timestamp |
| load_ready | output | 1 | Block is accepting batch tuples |
| old_valid | input | 1 | Streamed tuple offered |
| old_val | input | VAL_W | Streamed tuple value |
| old_ts | input | TS_W | Streamed tuple timestamp |
| old_last | input | 1 | Marks the final streamed tuple of the batch |
| old_ready | output | 1 | Block is accepting streamed tuples (0 while stalled) |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Downstream takes the result |
| res_val | output | VAL_W | Joined value |
| res_new_ts | output | TS_W | Batch tuple timestamp |
| res_old_ts | output | TS_W | Streamed tuple timestamp |
| res_ts | output | TS_W | Larger of the two timestamps |
| res_slot | output | $clog2(N) | Index of the matching element |
| batch_done | output | 1 | One-cycle batch completion pulse |

## Verification
Two things can land in the same cycle: a new match arriving at an element and that element's register still waiting to be drained. The bench provokes this with a batch in which all four elements hold the same value. Each streamed tuple then matches every element at once, while the result port accepts only one cycle in three. The collected results are compared, without regard to order, against a nested-loop reference computed in the bench. A lost or duplicated pair shows up as a count mismatch or as an unmatched result.

// File: rtl/sjoin_pkg.sv
package sjoin_pkg;
  typedef enum logic {PH_LOAD = 1'b0, PH_STREAM = 1'b1} phase_t;
endpackage

// File: rtl/sjoin_cell.sv
module sjoin_cell #(
  parameter int VAL_W = 16,
  parameter int TS_W  = 16,
  parameter int WIN   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [VAL_W-1:0] ld_val,
  input  logic [TS_W-1:0]  ld_ts,
  input  logic             probe_vld,
  input  logic [VAL_W-1:0] probe_val,
  input  logic [TS_W-1:0]  probe_ts,
  input  logic             advance,
  input  logic             take,
  output logic             hit,
  output logic             full,
  output logic [VAL_W-1:0] p_val,
  output logic [TS_W-1:0]  p_new_ts,
  output logic [TS_W-1:0]  p_old_ts
);
  localparam logic [TS_W-1:0] WIN_T = TS_W'(WIN);

  logic [VAL_W-1:0] key_val;
  logic [TS_W-1:0]  key_ts;
  logic [TS_W-1:0]  gap;

  always_ff @(posedge clk) begin
    if (ld_en) begin
      key_val <= ld_val;
      key_ts  <= ld_ts;
    end
  end

  always_comb begin
    gap = (probe_ts >= key_ts) ? (probe_ts - key_ts) : (key_ts - probe_ts);
    hit = probe_vld && (probe_val == key_val) && (gap <= WIN_T);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (take) begin
      full <= 1'b0;
    end else if (advance && hit) begin
      full <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (advance && hit) begin
      p_val    <= probe_val;
      p_new_ts <= key_ts;
      p_old_ts <= probe_ts;
    end
  end

  // R5
  cell_no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && hit) |-> !full);

  // R5
  cell_take_full_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> full);
endmodule

// File: rtl/sjoin_rr_arb.sv
module sjoin_rr_arb #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  input  logic                 en,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gidx
);
  localparam int IDX_W = $clog2(N);

  logic [IDX_W-1:0] ptr;
  logic             found;

  always_comb begin
    gnt   = '0;
    gidx  = '0;
    found = 1'b0;
    for (int o = 0; o < N; o++) begin
      int j;
      j = (int'(ptr) + o) % N;
      if (!found && en && req[j]) begin
        gnt[j] = 1'b1;
        gidx   = IDX_W'(j);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (found) begin
      if (int'(gidx) == N - 1) ptr <= '0;
      else                     ptr <= gidx + 1'b1;
    end
  end

  // R5
  arb_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  // R5
  arb_req_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);
endmodule

// File: rtl/sjoin_array.sv
module sjoin_array
  import sjoin_pkg::*;
#(
  parameter int N     = 4,
  parameter int VAL_W = 16,
  parameter int TS_W  = 16,
  parameter int WIN   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_valid,
  input  logic [VAL_W-1:0]     load_val,
  input  logic [TS_W-1:0]      load_ts,
  output logic                 load_ready,
  input  logic                 old_valid,
  input  logic [VAL_W-1:0]     old_val,
  input  logic [TS_W-1:0]      old_ts,
  input  logic                 old_last,
  output logic                 old_ready,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [VAL_W-1:0]     res_val,
  output logic [TS_W-1:0]      res_new_ts,
  output logic [TS_W-1:0]      res_old_ts,
  output logic [TS_W-1:0]      res_ts,
  output logic [$clog2(N)-1:0] res_slot,
  output logic                 batch_done
);
  localparam int IDX_W = $clog2(N);
  localparam int CNT_W = $clog2(N + 1);
  localparam logic [TS_W-1:0] WIN_T = TS_W'(WIN);

  phase_t           phase;
  logic [CNT_W-1:0] load_cnt;
  logic             got_last;

  logic [N-1:0]     pv;
  logic [VAL_W-1:0] pval [N];
  logic [TS_W-1:0]  pts  [N];

  logic [N-1:0]     hit, full, gnt;
  logic [IDX_W-1:0] gidx;
  logic [VAL_W-1:0] c_val [N];
  logic [TS_W-1:0]  c_nts [N];
  logic [TS_W-1:0]  c_ots [N];

  logic stall, advance, accept, load_take, out_free, drained;

  always_comb begin
    stall      = |(hit & full);
    advance    = (phase == PH_STREAM) && !stall;
    load_ready = (phase == PH_LOAD);
    old_ready  = advance && !got_last;
    accept     = old_valid && old_ready;
    load_take  = load_valid && load_ready;
    out_free   = !res_valid || res_ready;
    drained    = got_last && (pv == '0) && (full == '0) && !res_valid;
  end

  // phase control
  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_LOAD;
      load_cnt   <= '0;
      got_last   <= 1'b0;
      batch_done <= 1'b0;
    end else begin
      batch_done <= 1'b0;
      if (phase == PH_LOAD) begin
        if (load_take) begin
          if (int'(load_cnt) == N - 1) begin
            load_cnt <= '0;
            got_last <= 1'b0;
            phase    <= PH_STREAM;
          end else begin
            load_cnt <= load_cnt + 1'b1;
          end
        end
      end else begin
        if (accept && old_last) got_last <= 1'b1;
        if (drained) begin
          phase      <= PH_LOAD;
          batch_done <= 1'b1;
        end
      end
    end
  end

  // streamed tuple pipeline
  always_ff @(posedge clk) begin
    if (rst) begin
      pv <= '0;
    end else if (advance) begin
      pv[0] <= accept;
      for (int k = 1; k < N; k++) pv[k] <= pv[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      pval[0] <= old_val;
      pts[0]  <= old_ts;
      for (int k = 1; k < N; k++) begin
        pval[k] <= pval[k-1];
        pts[k]  <= pts[k-1];
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cell
    logic ld_en_g;
    assign ld_en_g = load_take && (int'(load_cnt) == g);
    sjoin_cell #(.VAL_W(VAL_W), .TS_W(TS_W), .WIN(WIN)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .ld_en    (ld_en_g),
      .ld_val   (load_val),
      .ld_ts    (load_ts),
      .probe_vld(pv[g]),
      .probe_val(pval[g]),
      .probe_ts (pts[g]),
      .advance  (advance),
      .take     (gnt[g]),
      .hit      (hit[g]),
      .full     (full[g]),
      .p_val    (c_val[g]),
      .p_new_ts (c_nts[g]),
      .p_old_ts (c_ots[g])
    );
  end

  sjoin_rr_arb #(.N(N)) u_arb (
    .clk (clk),
    .rst (rst),
    .req (full),
    .en  (out_free),
    .gnt (gnt),
    .gidx(gidx)
  );

  // registered result port
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
    end else if (|gnt) begin
      res_valid <= 1'b1;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (|gnt) begin
      res_val    <= c_val[gidx];
      res_new_ts <= c_nts[gidx];
      res_old_ts <= c_ots[gidx];
      res_ts     <= (c_nts[gidx] >= c_ots[gidx]) ? c_nts[gidx] : c_ots[gidx];
      res_slot   <= gidx;
    end
  end

  logic [TS_W-1:0] res_gap;
  assign res_gap = (res_old_ts >= res_new_ts) ? (res_old_ts - res_new_ts)
                                              : (res_new_ts - res_old_ts);

  // R6
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_val) &&
      $stable(res_new_ts) && $stable(res_old_ts) && $stable(res_ts) &&
      $stable(res_slot)));

  // R7
  done_clean_chk: assert property (@(posedge clk) disable iff (rst)
    batch_done |-> (!res_valid && load_ready && !old_ready));

  // R2
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(load_ready && old_ready));

  // R3
  res_window_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_gap <= WIN_T));
endmodule

// File: tb/sjoin_array_test.sv
module sjoin_array_test;
  localparam int N   = 4;
  localparam int VW  = 16;
  localparam int TW  = 16;
  localparam int WIN = 8;
  localparam int NB  = 4;
  localparam int NO  = 6;
  localparam int MAXR = 64;

  localparam int NEWV [NB][N] = '{'{5,7,5,9}, '{3,3,3,3}, '{1,2,3,4}, '{4,4,6,6}};
  localparam int NEWT [NB][N] = '{'{100,100,120,50}, '{10,12,14,16},
                                  '{200,200,200,200}, '{0,5,0,8}};
  localparam int OLDV [NB][NO] = '{'{5,7,5,3,9,5}, '{3,3,3,3,3,3},
                                   '{5,6,7,8,1,2}, '{4,6,4,6,4,6}};
  localparam int OLDT [NB][NO] = '{'{92,108,109,100,50,128}, '{13,13,13,13,30,3},
                                   '{100,100,100,100,209,191}, '{8,0,13,16,3,9}};
  // 0: always ready, 1: ready one cycle in three, 2: ready every other cycle
  localparam int MODE [NB] = '{0, 1, 0, 2};

  logic clk = 1'b0;
  logic rst;
  logic load_valid, load_ready, old_valid, old_last, old_ready;
  logic [VW-1:0] load_val, old_val, res_val;
  logic [TW-1:0] load_ts, old_ts, res_new_ts, res_old_ts, res_ts;
  logic res_valid, res_ready, batch_done;
  logic [1:0] res_slot;

  always #2 clk = ~clk;

  sjoin_array #(.N(N), .VAL_W(VW), .TS_W(TW), .WIN(WIN)) uut (
    .clk(clk), .rst(rst),
    .load_valid(load_valid), .load_val(load_val), .load_ts(load_ts),
    .load_ready(load_ready),
    .old_valid(old_valid), .old_val(old_val), .old_ts(old_ts),
    .old_last(old_last), .old_ready(old_ready),
    .res_valid(res_valid), .res_ready(res_ready), .res_val(res_val),
    .res_new_ts(res_new_ts), .res_old_ts(res_old_ts), .res_ts(res_ts),
    .res_slot(res_slot), .batch_done(batch_done)
  );

  int n_tests = 0;
  int n_fail  = 0;

  int e_val [MAXR], e_nts [MAXR], e_ots [MAXR], e_slot [MAXR];
  bit e_used [MAXR];
  int nexp;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic take_result(input int b);
    bit found = 0;
    int mx;
    for (int i = 0; i < nexp; i++) begin
      if (!found && !e_used[i] && e_slot[i] == int'(res_slot) &&
          e_val[i] == int'(res_val) && e_nts[i] == int'(res_new_ts) &&
          e_ots[i] == int'(res_old_ts)) begin
        found = 1;
        e_used[i] = 1;
      end
    end
    // R3 R5: each result must be an expected, not yet seen pair
    chk(found, $sformatf("R3 R5 batch %0d unexpected pair slot", b),
        int'(res_slot), -1);
    mx = (res_new_ts >= res_old_ts) ? int'(res_new_ts) : int'(res_old_ts);
    // R4: merged timestamp is the later one
    chk(int'(res_ts) == mx, $sformatf("R4 batch %0d res_ts", b), int'(res_ts), mx);
  endtask

  task automatic run_batch(input int b);
    int li = 0, oi = 0, cyc = 0, nrec = 0;
    bit done_seen = 0, r2_done = 0, hold_pend = 0;
    int h_val = 0, h_nts = 0, h_ots = 0, h_ts = 0, h_slot = 0;
    int d;

    nexp = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < NO; j++) begin
        d = NEWT[b][i] - OLDT[b][j];
        if (d < 0) d = -d;
        if (NEWV[b][i] == OLDV[b][j] && d <= WIN) begin
          e_val[nexp] = NEWV[b][i]; e_nts[nexp] = NEWT[b][i];
          e_ots[nexp] = OLDT[b][j]; e_slot[nexp] = i; e_used[nexp] = 0;
          nexp++;
        end
      end

    while (!done_seen && cyc < 3000) begin
      @(negedge clk);
      load_valid = (li < N);
      load_val   = VW'(NEWV[b][(li < N) ? li : 0]);
      load_ts    = TW'(NEWT[b][(li < N) ? li : 0]);
      old_valid  = (li == N) && (oi < NO);
      old_val    = VW'(OLDV[b][(oi < NO) ? oi : 0]);
      old_ts     = TW'(OLDT[b][(oi < NO) ? oi : 0]);
      old_last   = (oi == NO - 1);
      case (MODE[b])
        1:       res_ready = (cyc % 3 == 0);
        2:       res_ready = cyc[0];
        default: res_ready = 1'b1;
      endcase
      #1;
      if (li == N && !r2_done) begin
        // R2: loading closes and streaming opens after N handshakes
        chk(!load_ready && old_ready, $sformatf("R2 batch %0d ready pair", b),
            {load_ready, old_ready}, 1);
        r2_done = 1;
      end
      if (hold_pend) begin
        // R6: stalled output stays put
        chk(res_valid && int'(res_val) == h_val && int'(res_new_ts) == h_nts &&
            int'(res_old_ts) == h_ots && int'(res_ts) == h_ts &&
            int'(res_slot) == h_slot, $sformatf("R6 batch %0d held ts", b),
            int'(res_ts), h_ts);
      end
      hold_pend = res_valid && !res_ready;
      h_val = int'(res_val); h_nts = int'(res_new_ts); h_ots = int'(res_old_ts);
      h_ts = int'(res_ts); h_slot = int'(res_slot);
      if (batch_done) begin
        done_seen = 1;
        // R7: done only with port empty and loading reopened
        chk(load_ready && !res_valid, $sformatf("R7 batch %0d done state", b),
            {load_ready, res_valid}, 2);
      end
      if (res_valid && res_ready) begin
        nrec++;
        take_result(b);
      end
      if (load_valid && load_ready) li++;
      if (old_valid && old_ready) oi++;
      cyc++;
    end
    load_valid = 0; old_valid = 0; old_last = 0;
    chk(done_seen, $sformatf("R7 batch %0d done pulse seen", b), done_seen, 1);
    if (nexp == 0)
      chk(nrec == 0, $sformatf("R8 batch %0d result count", b), nrec, 0);
    else
      chk(nrec == nexp, $sformatf("R5 batch %0d result count", b), nrec, nexp);
    // R7: nothing more comes out after done
    res_ready = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk(!res_valid && !batch_done, $sformatf("R7 batch %0d idle after done", b),
          res_valid, 0);
    end
  endtask

  initial begin
    rst = 1; load_valid = 0; load_val = 0; load_ts = 0;
    old_valid = 0; old_val = 0; old_ts = 0; old_last = 0; res_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    // R1: reset state
    chk(!res_valid && !batch_done && load_ready && !old_ready, "R1 reset outputs",
        {res_valid, batch_done, load_ready, old_ready}, 2);
    for (int b = 0; b < NB; b++) run_batch(b);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule